// File: doc/BRIEF.md
# Five-Mode Barrel Shifter With Carry

This is a purely combinational shifter for the operand path of an integer datapath. It takes one operand and shifts or rotates it in one of five ways: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry. Alongside the result it produces a carry-out: the last bit that left the operand.

The shift distance comes from one of two sources, picked by a select input. The first is a short immediate field, which is as wide as the log2 of the operand width. The second is the low byte of a register value. In immediate form, a zero field has a special meaning. For the two right shifts it stands for a full-width shift. For the rotate type it selects the one-bit rotate through the carry. In register form every distance from 0 to 255 gives a defined result and a defined carry, including distances of the full width or more.

Top module: `barrel_shift_carry`

## Requirements
- R1: Shift type codes are: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right through carry. For immediate logical left with field k (0..WIDTH-1), the result is the operand shifted left by k with zeros in the vacated bits, and the carry is operand bit WIDTH-k. A field of 0 passes the operand through and copies carry-in to carry-out.
- R2: For immediate logical right, a field k of 1..WIDTH-1 shifts right by k with zero fill, and the carry is operand bit k-1. A field of 0 means a shift of WIDTH: the result is zero and the carry is the operand's top bit.
- R3: For immediate arithmetic right, a field k of 1..WIDTH-1 shifts right by k and fills with copies of the top bit, and the carry is operand bit k-1. A field of 0 means WIDTH: every result bit and the carry equal the operand's top bit.
- R4: For immediate rotate right, a non-zero field k rotates right by k, and the carry equals the new top result bit. A zero field performs the rotate through carry of R5.
- R5: Type 4 produces {carry_in, operand[WIDTH-1:1]} with carry-out equal to operand bit 0, whatever the amount inputs and the select hold.
- R6: When the select is 1, the distance is the 8-bit register amount and the immediate field has no effect. A register distance of 0 passes both the operand and carry-in through for types 0 to 3. A distance between 1 and WIDTH-1 behaves as the same immediate distance would.
- R7: A register distance of exactly WIDTH gives a zero result for both logical shifts. The carry is operand bit 0 for the left shift and operand bit WIDTH-1 for the right shift.
- R8: A register distance above WIDTH gives a zero result and a zero carry for both logical shifts.
- R9: An arithmetic right shift by a register distance of WIDTH or more fills the result and the carry with the operand's top bit.
- R10: Rotate right by a register distance uses that distance modulo WIDTH. A non-zero multiple of WIDTH returns the operand unchanged, with carry equal to its top bit.
- R11: Type codes 5 to 7 pass the operand and carry-in through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | WIDTH | Operand to shift |
| kind_i | input | 3 | Shift type code |
| use_reg_i | input | 1 | 1 selects the register distance, 0 the immediate field |
| imm_amt_i | input | log2(WIDTH) | Immediate distance field |
| reg_amt_i | input | REG_AMT_W | Register-sourced distance |
| carry_i | input | 1 | Carry-in |
| result_o | output | WIDTH | Shifted value |
| carry_o | output | 1 | Last bit shifted out |

## Verification
On every input change, the assertions check several properties. Pass-through holds for the spare codes and for a zero register distance. The vacated top bit of a logical right shift is zero. The low bits vacated by a left shift are zero. An arithmetic shift keeps the sign. A rotate keeps the number of set bits. A rotate through carry places carry-in at the top and bit 0 in the carry. The exact carry bit at each distance cannot be shown by those properties. Neither can the meaning of a zero immediate field, or the boundary at exactly WIDTH against distances above it. The bench covers these by sweeping every immediate value and all 256 register distances for each type, against several operands and both carry-in values.

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry #(
  parameter int WIDTH     = 32,
  parameter int REG_AMT_W = 8,
  localparam int IMM_W    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]     opnd_i,
  input  logic [2:0]           kind_i,
  input  logic                 use_reg_i,
  input  logic [IMM_W-1:0]     imm_amt_i,
  input  logic [REG_AMT_W-1:0] reg_amt_i,
  input  logic                 carry_i,
  output logic [WIDTH-1:0]     result_o,
  output logic                 carry_o
);

  localparam int AMT_W = (REG_AMT_W > IMM_W + 1) ? REG_AMT_W : IMM_W + 1;

  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic [AMT_W-1:0] amt;
  logic             do_rrx;
  logic [WIDTH:0]   lsl_v, lsr_v, asr_v;
  logic [WIDTH-1:0] ror_v;

  assign do_rrx = (kind_i == K_RRX) ||
                  (kind_i == K_ROR && !use_reg_i && imm_amt_i == '0);

  always_comb begin
    if (use_reg_i)
      amt = AMT_W'(reg_amt_i);
    else if (imm_amt_i == '0 && (kind_i == K_LSR || kind_i == K_ASR))
      amt = AMT_W'(WIDTH);
    else
      amt = AMT_W'(imm_amt_i);
  end

  assign lsl_v = {1'b0, opnd_i} << amt;
  assign lsr_v = {opnd_i, 1'b0} >> amt;
  assign asr_v = $unsigned($signed({opnd_i, 1'b0}) >>> amt);
  assign ror_v = (opnd_i >> amt[IMM_W-1:0]) |
                 (opnd_i << (WIDTH - int'(amt[IMM_W-1:0])));

  always_comb begin
    result_o = opnd_i;
    carry_o  = carry_i;
    if (do_rrx) begin
      result_o = {carry_i, opnd_i[WIDTH-1:1]};
      carry_o  = opnd_i[0];
    end else if (amt != '0) begin
      case (kind_i)
        K_LSL: {carry_o, result_o} = lsl_v;
        K_LSR: {result_o, carry_o} = lsr_v;
        K_ASR: {result_o, carry_o} = asr_v;
        K_ROR: begin
          result_o = ror_v;
          carry_o  = ror_v[WIDTH-1];
        end
        default: ;
      endcase
    end
  end

  // Port-level checks, R-tags in labels
  logic [AMT_W-1:0] port_amt;
  assign port_amt = use_reg_i ? AMT_W'(reg_amt_i) : AMT_W'(imm_amt_i);

  always_comb begin
    if (kind_i > K_RRX)
      a_r11_spare_pass: assert (result_o == opnd_i && carry_o == carry_i);
    if (use_reg_i && reg_amt_i == '0 && kind_i != K_RRX)
      a_r6_zero_reg_pass: assert (result_o == opnd_i && carry_o == carry_i);
    if (kind_i == K_LSR && (!use_reg_i || reg_amt_i != '0))
      a_r2_lsr_top_zero: assert (result_o[WIDTH-1] == 1'b0);
    if (kind_i == K_LSL && port_amt != '0)
      a_r1_lsl_low_zero: assert ((result_o & ~({WIDTH{1'b1}} << port_amt)) == '0);
    if (kind_i == K_ASR)
      a_r3_asr_sign_kept: assert (result_o[WIDTH-1] == opnd_i[WIDTH-1]);
    if (kind_i == K_ROR && (use_reg_i || imm_amt_i != '0))
      a_r10_ror_popcount: assert ($countones(result_o) == $countones(opnd_i));
    if (kind_i == K_RRX)
      a_r5_rrx_carry: assert (carry_o == opnd_i[0] && result_o[WIDTH-1] == carry_i);
  end

endmodule

// File: tb/barrel_shift_carry_test.sv
module barrel_shift_carry_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd;
  logic [2:0]   kind;
  logic         use_reg;
  logic [4:0]   imm;
  logic [7:0]   ramt;
  logic         cin;
  logic [W-1:0] res;
  logic         cout;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  barrel_shift_carry uut (
    .opnd_i(opnd), .kind_i(kind), .use_reg_i(use_reg), .imm_amt_i(imm),
    .reg_amt_i(ramt), .carry_i(cin), .result_o(res), .carry_o(cout)
  );

  logic [W-1:0] ops [6];
  initial begin
    ops[0] = 32'h0000_0000; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h8000_0001;
    ops[3] = 32'h1234_5678; ops[4] = 32'hA5F0_0F5A; ops[5] = 32'h7FFF_FFFE;
  end

  // bit-serial reference model
  task automatic model(input logic [W-1:0] v0, input logic [2:0] k, input logic ur,
                       input logic [4:0] im, input logic [7:0] ra, input logic c0,
                       output logic [W-1:0] v, output logic c);
    int n;
    logic [2:0] kk;
    v = v0; c = c0; kk = k;
    n = ur ? int'(ra) : int'(im);
    if (!ur && im == 0 && (k == 3'd1 || k == 3'd2)) n = W;
    if (!ur && im == 0 && k == 3'd3) kk = 3'd4;
    if (kk == 3'd4) begin
      c = v0[0]; v = {c0, v0[W-1:1]};
    end else if (kk < 3'd4) begin
      for (int i = 0; i < n; i++) begin
        case (kk)
          3'd0: begin c = v[W-1]; v = {v[W-2:0], 1'b0}; end
          3'd1: begin c = v[0];   v = {1'b0, v[W-1:1]}; end
          3'd2: begin c = v[0];   v = {v[W-1], v[W-1:1]}; end
          default: begin c = v[0]; v = {v[0], v[W-1:1]}; end
        endcase
      end
    end
  endtask

  function automatic string tag(input logic [2:0] k, input logic ur,
                                input logic [4:0] im, input logic [7:0] ra);
    if (k > 3'd4) return "R11";
    if (k == 3'd4) return "R5";
    if (!ur) begin
      case (k)
        3'd0: return "R1";
        3'd1: return "R2";
        3'd2: return "R3";
        default: return (im == 0) ? "R4/R5" : "R4";
      endcase
    end
    if (ra == 0) return "R6";
    if (k == 3'd3) return (ra >= 8'd32) ? "R10" : "R6";
    if (k == 3'd2) return (ra >= 8'd32) ? "R9" : "R6";
    if (ra == 8'd32) return "R7";
    if (ra > 8'd32) return "R8";
    return "R6";
  endfunction

  task automatic apply_check(input logic [W-1:0] v0, input logic [2:0] k, input logic ur,
                             input logic [4:0] im, input logic [7:0] ra, input logic c0);
    logic [W-1:0] ev;
    logic ec;
    opnd = v0; kind = k; use_reg = ur; imm = im; ramt = ra; cin = c0;
    @(negedge clk);
    model(v0, k, ur, im, ra, c0, ev, ec);
    total++;
    if (res !== ev || cout !== ec) begin
      bad++;
      $display("FAIL %s kind=%0d reg=%0b imm=%0d ramt=%0d op=%h cin=%0b: got %h/%0b exp %h/%0b",
               tag(k, ur, im, ra), k, ur, im, ra, v0, c0, res, cout, ev, ec);
    end
  endtask

  initial begin
    opnd = '0; kind = '0; use_reg = 1'b0; imm = '0; ramt = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // idle inputs: R1 zero immediate pass-through
    apply_check('0, 3'd0, 1'b0, 5'd0, 8'd0, 1'b0);
    for (int o = 0; o < 6; o++)
      for (int k = 0; k < 8; k++)
        for (int c = 0; c < 2; c++) begin
          // immediate sweep, register amount set to a distractor (R6)
          for (int a = 0; a < 32; a++)
            apply_check(ops[o], 3'(k), 1'b0, 5'(a), 8'(255 - a * 7), 1'(c));
          // register sweep, immediate set to a distractor (R6..R10)
          for (int a = 0; a < 256; a++)
            apply_check(ops[o], 3'(k), 1'b1, 5'(a * 3 + 1), 8'(a), 1'(c));
        end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule